// File: doc/BRIEF.md
# Open-NAND Compliance Probe Sequencer

This block decides whether the NAND device on an 8-bit asynchronous bus follows the open NAND interface standard. A pulse on `start` begins the probe. The block first sends an ID read at the signature address and compares the four returned bytes with the ASCII text "ONFI". If the text matches, it sends the parameter-page read and waits for the device to finish its internal load. It then pulls in the redundant 256-byte copies of the page one after another. It checks each copy against the 16-bit CRC held in that copy's last two bytes. The first copy that passes ends the probe.

The block does not drive the device pins itself. It asks a lower-level bus engine for work over a valid/ready request channel: a command byte, an address byte, or one data read. Read data comes back on a second valid/ready channel. Both channels follow the usual back-pressure rules. Once `req_valid` is raised, the request stays unchanged until `req_ready` is seen high at a clock edge. A data byte moves only on an edge where `rdat_valid` and `rdat_ready` are both high, and `rdat_ready` is raised only while a read is outstanding. A one-cycle `done` pulse marks the end of a probe. The `detected` and `failed` flags and the accepted copy index then hold their values until the next probe starts.

Top module: `onfi_probe_seq`

## Requirements
- R1: After an accepted start, the first two requests are a command (req_op 0) with byte 0x90, then an address (req_op 1) with byte 0x20.
- R2: The next four reads (req_op 2) must return 0x4F, 0x4E, 0x46, 0x49 in that order. On the first byte that differs, the probe ends with failed=1 and detected=0. No further read is issued and no 0xEC command is sent.
- R3: After a matching signature, the next requests are a command with byte 0xEC and then an address with byte 0x00.
- R4: After the 0xEC address handshake, no read request is issued until at least WB_CYC cycles have passed and rb_ready is high.
- R5: A page copy passes when the CRC of its bytes 0 to 253 equals bytes 254 (low) and 255 (high). The CRC is 16 bits wide, starts from 0x4F4E, uses polynomial 0x8005, and shifts MSB first, with each byte XORed into the top eight bits.
- R6: Copies are read back to back without a new command. The first passing copy sets detected=1 and copy_idx to its index (0 to 2), and no further read is issued.
- R7: If all three copies fail, the probe ends with failed=1 and detected=0 after exactly 768 page reads.
- R8: `done` is high for exactly one cycle per probe. The flags and copy_idx are set in the same cycle as `done` and stay stable afterwards. The flags clear on the edge that accepts the next start.
- R9: A start pulse during an active probe is ignored, so no second 0x90 command is issued.
- R10: A request with `req_valid` high and `req_ready` low is held unchanged in op and byte, and the sequence of requests is unaffected by stalls.
- R11: Out of reset, req_valid, rdat_ready, done, detected and failed are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe (taken only when idle) |
| rb_ready | input | 1 | Device ready/busy line, 1 = ready |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus engine accepts the request |
| req_op | output | 2 | 0 = command, 1 = address, 2 = data read |
| req_byte | output | 8 | Command or address byte |
| rdat_valid | input | 1 | Read data valid |
| rdat_ready | output | 1 | Sequencer can take a read byte |
| rdat_byte | input | 8 | Read data byte |
| done | output | 1 | One-cycle end-of-probe pulse |
| detected | output | 1 | Sticky: compliant device with a valid page |
| failed | output | 1 | Sticky: bad signature or no valid copy |
| copy_idx | output | 2 | Index of the accepted copy |

## Verification
A start takes effect on the edge that samples it, so the flags are checked clear at the following falling edge. The outcome is read at the falling edge where `done` is first seen. It is read again four cycles later to confirm that the flags hold and that no further read request has appeared. The device model in the bench responds two nanoseconds after each rising edge and records every handshake at the falling edge before it. This lets command order, read counts and ready/busy violations be counted exactly, without depending on the order of processes at an edge.

// File: rtl/onfi_probe_pkg.sv
package onfi_probe_pkg;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_READ = 2'd2
  } bus_op_e;

  localparam logic [7:0]  CMD_READ_ID  = 8'h90;
  localparam logic [7:0]  ADDR_SIG     = 8'h20;
  localparam logic [7:0]  CMD_PARAM_PG = 8'hEC;
  localparam logic [7:0]  ADDR_PARAM   = 8'h00;
  localparam logic [31:0] SIG_TEXT     = 32'h4F4E4649;
  localparam logic [15:0] PAGE_CRC_SEED = 16'h4F4E;
  localparam logic [15:0] PAGE_CRC_POLY = 16'h8005;

endpackage

// File: rtl/onfi_crc_acc.sv
module onfi_crc_acc #(
  parameter logic [15:0] SEED = 16'h4F4E,
  parameter logic [15:0] POLY = 16'h8005
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  function automatic logic [15:0] fold_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) begin
      r = r[15] ? ((r << 1) ^ POLY) : (r << 1);
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= SEED;
    else if (clr) crc <= SEED;
    else if (en)  crc <= fold_byte(crc, din);
  end

endmodule

// File: rtl/onfi_sig_cmp.sv
module onfi_sig_cmp #(
  parameter int          SIG_LEN  = 4,
  parameter logic [31:0] SIG_WORD = 32'h4F4E4649,
  localparam int         POS_W    = (SIG_LEN > 1) ? $clog2(SIG_LEN) : 1
) (
  input  logic [POS_W-1:0] pos,
  input  logic [7:0]       din,
  output logic             match
);

  logic [7:0] expect_b [SIG_LEN];

  for (genvar g = 0; g < SIG_LEN; g++) begin : g_sig
    assign expect_b[g] = SIG_WORD[8*(SIG_LEN-1-g) +: 8];
  end

  assign match = (din == expect_b[pos]);

endmodule

// File: rtl/onfi_settle_timer.sv
module onfi_settle_timer #(
  parameter int  WB_CYC = 4,
  localparam int CNT_W  = $clog2(WB_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic rb_ready,
  output logic go
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (arm)         cnt <= CNT_W'(WB_CYC);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign go = (cnt == '0) && rb_ready;

endmodule

// File: rtl/onfi_probe_seq.sv
module onfi_probe_seq
  import onfi_probe_pkg::*;
#(
  parameter int  PAGE_BYTES = 256,
  parameter int  COPIES     = 3,
  parameter int  WB_CYC     = 4,
  localparam int IDX_W      = $clog2(PAGE_BYTES),
  localparam int CP_W       = (COPIES > 1) ? $clog2(COPIES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rb_ready,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [1:0]      req_op,
  output logic [7:0]      req_byte,
  input  logic            rdat_valid,
  output logic            rdat_ready,
  input  logic [7:0]      rdat_byte,
  output logic            done,
  output logic            detected,
  output logic            failed,
  output logic [CP_W-1:0] copy_idx
);

  localparam logic [IDX_W-1:0] LO_POS   = IDX_W'(PAGE_BYTES - 2);
  localparam logic [IDX_W-1:0] HI_POS   = IDX_W'(PAGE_BYTES - 1);
  localparam logic [CP_W-1:0]  LAST_CP  = CP_W'(COPIES - 1);
  localparam logic [1:0]       SIG_LAST = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_ID_CMD, S_ID_ADDR, S_SIG_REQ, S_SIG_DAT,
    S_PP_CMD, S_PP_ADDR, S_SETTLE, S_PG_REQ, S_PG_DAT,
    S_CHECK, S_DONE
  } seq_st_e;

  seq_st_e          st;
  logic [IDX_W-1:0] bidx;
  logic [CP_W-1:0]  copy;
  logic [1:0]       sidx;
  logic [7:0]       ref_lo, ref_hi;
  logic [15:0]      crc_now;
  logic             sig_ok, settle_go;
  logic             fire, take, pass, crc_clr, crc_en;
  bus_op_e          op_sel;

  always_comb begin
    req_valid = 1'b0;
    op_sel    = OP_CMD;
    req_byte  = 8'h00;
    unique case (st)
      S_ID_CMD:  begin req_valid = 1'b1; op_sel = OP_CMD;  req_byte = CMD_READ_ID;  end
      S_ID_ADDR: begin req_valid = 1'b1; op_sel = OP_ADDR; req_byte = ADDR_SIG;     end
      S_PP_CMD:  begin req_valid = 1'b1; op_sel = OP_CMD;  req_byte = CMD_PARAM_PG; end
      S_PP_ADDR: begin req_valid = 1'b1; op_sel = OP_ADDR; req_byte = ADDR_PARAM;   end
      S_SIG_REQ, S_PG_REQ: begin req_valid = 1'b1; op_sel = OP_READ; end
      default: ;
    endcase
  end

  assign req_op     = op_sel;
  assign rdat_ready = (st == S_SIG_DAT) || (st == S_PG_DAT);
  assign fire       = req_valid && req_ready;
  assign take       = rdat_valid && rdat_ready;
  assign done       = (st == S_DONE);
  assign pass       = (crc_now == {ref_hi, ref_lo});
  assign crc_en     = take && (st == S_PG_DAT) && (bidx < LO_POS);
  assign crc_clr    = ((st == S_PP_ADDR) && fire) ||
                      ((st == S_CHECK) && !pass && (copy != LAST_CP));

  onfi_crc_acc #(.SEED(PAGE_CRC_SEED), .POLY(PAGE_CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .din(rdat_byte), .crc(crc_now)
  );

  onfi_sig_cmp #(.SIG_LEN(4), .SIG_WORD(SIG_TEXT)) u_sig (
    .pos(sidx), .din(rdat_byte), .match(sig_ok)
  );

  onfi_settle_timer #(.WB_CYC(WB_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .arm((st == S_PP_ADDR) && fire),
    .rb_ready(rb_ready), .go(settle_go)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bidx     <= '0;
      copy     <= '0;
      sidx     <= '0;
      ref_lo   <= '0;
      ref_hi   <= '0;
      detected <= 1'b0;
      failed   <= 1'b0;
      copy_idx <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          st       <= S_ID_CMD;
          detected <= 1'b0;
          failed   <= 1'b0;
          copy_idx <= '0;
        end
        S_ID_CMD:  if (fire) st <= S_ID_ADDR;
        S_ID_ADDR: if (fire) begin st <= S_SIG_REQ; sidx <= '0; end
        S_SIG_REQ: if (fire) st <= S_SIG_DAT;
        S_SIG_DAT: if (take) begin
          if (!sig_ok) begin
            failed <= 1'b1;
            st     <= S_DONE;
          end else if (sidx == SIG_LAST) begin
            st <= S_PP_CMD;
          end else begin
            sidx <= sidx + 1'b1;
            st   <= S_SIG_REQ;
          end
        end
        S_PP_CMD:  if (fire) st <= S_PP_ADDR;
        S_PP_ADDR: if (fire) begin
          st   <= S_SETTLE;
          bidx <= '0;
          copy <= '0;
        end
        S_SETTLE:  if (settle_go) st <= S_PG_REQ;
        S_PG_REQ:  if (fire) st <= S_PG_DAT;
        S_PG_DAT: if (take) begin
          if (bidx == LO_POS) ref_lo <= rdat_byte;
          if (bidx == HI_POS) begin
            ref_hi <= rdat_byte;
            st     <= S_CHECK;
          end else begin
            bidx <= bidx + 1'b1;
            st   <= S_PG_REQ;
          end
        end
        S_CHECK: begin
          if (pass) begin
            detected <= 1'b1;
            copy_idx <= copy;
            st       <= S_DONE;
          end else if (copy == LAST_CP) begin
            failed <= 1'b1;
            st     <= S_DONE;
          end else begin
            copy <= copy + 1'b1;
            bidx <= '0;
            st   <= S_PG_REQ;
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_op) && $stable(req_byte)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(detected && failed));

  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    detected |-> (copy_idx <= LAST_CP));

  assert_settle_rb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_PG_REQ) && ($past(st) == S_SETTLE)) |-> $past(rb_ready));

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rdat_ready |-> !req_valid);

endmodule

// File: tb/sim_onfi_probe_seq.sv
module sim_onfi_probe_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic       rb_ready;
  logic       req_valid, req_ready;
  logic [1:0] req_op;
  logic [7:0] req_byte;
  logic       rdat_valid, rdat_ready;
  logic [7:0] rdat_byte;
  logic       done, detected, failed;
  logic [1:0] copy_idx;

  always #10 clk = ~clk;

  onfi_probe_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rb_ready(rb_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_byte(req_byte), .rdat_valid(rdat_valid), .rdat_ready(rdat_ready),
    .rdat_byte(rdat_byte), .done(done), .detected(detected),
    .failed(failed), .copy_idx(copy_idx)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {sigpos[2:0], badmask[2:0], stall, det, fail, idx[1:0], ec, reads[11:0]}
  localparam logic [23:0] VEC [8] = '{
    {3'd4, 3'b000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 12'd260},
    {3'd4, 3'b001, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 12'd516},
    {3'd4, 3'b011, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1, 12'd772},
    {3'd4, 3'b111, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 12'd772},
    {3'd0, 3'b000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 12'd1},
    {3'd3, 3'b000, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 12'd4},
    {3'd1, 3'b000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 12'd2},
    {3'd4, 3'b010, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 12'd260}
  };

  localparam logic [7:0] SIGB [4] = '{8'h4F, 8'h4E, 8'h46, 8'h49};

  // device model state
  int         mode, ptr, busy, busy_len, nreads, n90, nEC, rbviol, ndone, nlog, cyc;
  int         sigpos;
  bit         stall;
  logic [7:0] pg [768];
  logic [1:0] logo [8];
  logic [7:0] logb [8];

  function automatic logic [15:0] model_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h8005) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] dev_byte();
    if (mode == 1) begin
      if (ptr < 4) return SIGB[ptr] ^ ((ptr == sigpos) ? 8'h20 : 8'h00);
      return 8'h00;
    end
    if (mode == 2 && ptr < 768) return pg[ptr];
    return 8'h00;
  endfunction

  task automatic build_pages(input logic [2:0] badm);
    logic [15:0] c;
    logic [7:0]  lo, hi;
    for (int cp = 0; cp < 3; cp++) begin
      c = 16'h4F4E;
      for (int i = 0; i < 254; i++) begin
        pg[cp*256 + i] = 8'(i*5 + cp*29 + 3);
        c = model_crc(c, pg[cp*256 + i]);
      end
      lo = c[7:0];
      hi = c[15:8];
      if (badm[cp]) begin
        if (lo != hi) begin pg[cp*256+254] = hi; pg[cp*256+255] = lo; end
        else begin pg[cp*256+254] = lo; pg[cp*256+255] = hi ^ 8'h01; end
      end else begin
        pg[cp*256+254] = lo;
        pg[cp*256+255] = hi;
      end
    end
  endtask

  // device model: observe handshakes at falling edge, respond 2 ns after rising edge
  initial begin
    bit f, tk, dn, rbn;
    logic [1:0] fo;
    logic [7:0] fb;
    rb_ready = 1'b1; req_ready = 1'b1; rdat_valid = 1'b0; rdat_byte = 8'h00;
    mode = 0; ptr = 0; busy = 0; cyc = 0;
    forever begin
      @(negedge clk);
      f = req_valid && req_ready; fo = req_op; fb = req_byte;
      tk = rdat_valid && rdat_ready; dn = done; rbn = rb_ready;
      @(posedge clk);
      #2;
      cyc++;
      if (dn) ndone++;
      if (tk) begin rdat_valid = 1'b0; ptr++; end
      if (busy > 0) begin busy--; if (busy == 0) rb_ready = 1'b1; end
      if (f) begin
        if (fo == 2'd0 || fo == 2'd1) begin
          if (nlog < 8) begin logo[nlog] = fo; logb[nlog] = fb; end
          nlog++;
        end
        case (fo)
          2'd0: begin
            ptr = 0;
            if (fb == 8'h90) begin mode = 1; n90++; end
            else if (fb == 8'hEC) begin mode = 2; nEC++; end
            else mode = 0;
          end
          2'd1: if (mode == 2) begin busy = busy_len; rb_ready = 1'b0; end
          default: begin
            nreads++;
            if (!rbn) rbviol++;
            rdat_valid = 1'b1;
            rdat_byte  = dev_byte();
          end
        endcase
      end
      req_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    end
  end

  task automatic run_vec(input logic [23:0] v, input int vi, input bit extra_start, input int blen);
    bit         e_det, e_fail, e_ec, st_mode;
    logic [1:0] e_idx;
    int         e_reads, w;
    bit         cd, cf;
    logic [1:0] ci;
    string      tag;
    sigpos   = int'(v[23:21]);
    st_mode  = v[17];
    e_det    = v[16];
    e_fail   = v[15];
    e_idx    = v[14:13];
    e_ec     = v[12];
    e_reads  = int'(v[11:0]);
    build_pages(v[20:18]);
    nreads = 0; n90 = 0; nEC = 0; rbviol = 0; ndone = 0; nlog = 0;
    busy_len = blen;
    stall    = st_mode;
    tag = st_mode ? "R10" : "R1";
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    @(negedge clk);
    chk(!detected && !failed, "R8 flags cleared after start", {detected, failed}, 0);
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
      if (extra_start && w == 30) start = 1'b1;
      if (extra_start && w == 31) start = 1'b0;
    end
    if (!done) begin
      chk(1'b0, "R8 done never seen", 0, 1);
      return;
    end
    cd = detected; cf = failed; ci = copy_idx;
    repeat (4) @(negedge clk);
    $display("vector %0d: reads=%0d det=%0b fail=%0b idx=%0d", vi, nreads, cd, cf, ci);
    chk(ndone == 1, "R8 done pulse count", ndone, 1);
    chk(detected == cd && failed == cf && copy_idx == ci, "R8 flags sticky", {detected, failed}, {cd, cf});
    chk(cd == e_det, "R2/R6 detected", cd, e_det);
    chk(cf == e_fail, "R2/R7 failed", cf, e_fail);
    if (e_det) chk(ci == e_idx, "R5/R6 copy index", ci, e_idx);
    chk(nreads == e_reads, "R2/R6/R7 read count", nreads, e_reads);
    chk(nEC == int'(e_ec), "R2/R3 param command count", nEC, e_ec);
    chk(n90 == 1, extra_start ? "R9 single id command" : "R1 single id command", n90, 1);
    chk(nlog >= 2 && logo[0] == 2'd0 && logb[0] == 8'h90, {tag, " first request"}, logb[0], 8'h90);
    chk(logo[1] == 2'd1 && logb[1] == 8'h20, {tag, " id address"}, logb[1], 8'h20);
    if (e_ec) begin
      chk(nlog == 4 && logo[2] == 2'd0 && logb[2] == 8'hEC, "R3 param command", logb[2], 8'hEC);
      chk(logo[3] == 2'd1 && logb[3] == 8'h00, "R3 param address", logb[3], 8'h00);
    end else begin
      chk(nlog == 2, "R2 no request after mismatch", nlog, 2);
    end
    chk(rbviol == 0, "R4 read while busy", rbviol, 0);
    chk(!req_valid, "R6 idle after done", req_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!req_valid && !rdat_ready, "R11 bus idle in reset", {req_valid, rdat_ready}, 0);
    chk(!done && !detected && !failed, "R11 status low in reset", {done, detected, failed}, 0);
    #3 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!req_valid && !done, "R11 idle after reset", {req_valid, done}, 0);

    for (int i = 0; i < 8; i++) run_vec(VEC[i], i, 1'b0, 6);

    // R9: start during an active probe
    run_vec(VEC[0], 8, 1'b1, 6);
    // R4: long busy window after the parameter-page command
    run_vec(VEC[1], 9, 1'b0, 60);
    // R8: flags from a failed probe cleared by the next start
    run_vec(VEC[3], 10, 1'b0, 3);
    run_vec(VEC[2], 11, 1'b0, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule